// File: doc/BRIEF.md
# Serial PLL Status Frame Transmitter

This block sends one fixed-length status frame per video line on a single output pin. The frame reports the horizontal line-lock loop increment, the colour-subcarrier loop increment and a colour-standard sequence bit. It sends one bit per time slot, and each slot lasts four pixel-clock periods. A receiver locks onto the frame at the high-to-low edge of the start slot. It then counts slots to recover each field. A valid flag marks the slots that carry meaningful content.

The line-timing logic raises a frame request once per line. At that point the block captures the two increments, the colour standard and the line-phase flag. It then serializes them over 68 slots. Between frames the pin rests high, and a request that arrives while a frame is being sent has no effect.

Top module: `ser_pll_frame_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sdo_o` is 1 and `valid_o` is 0.
- R2: While no frame is in progress, `sdo_o` is 1 and `valid_o` is 0.
- R3: A request seen at a clock edge while idle starts a frame. From the next cycle onward, each slot lasts exactly 4 cycles, and slot 0 drives 0, which gives the high-to-low start edge.
- R4: Slots 1 to 14 carry the captured horizontal increment, bit 13 in slot 1 down to bit 0 in slot 14.
- R5: Slots 15 to 17 and slots 42 to 67 are reserved and drive 0.
- R6: Slots 18 to 40 carry the captured subcarrier increment, bit 22 in slot 18 down to bit 0 in slot 40.
- R7: Slot 41 carries the sequence bit. The standard code is 0 for NTSC, where the bit is always 0. Code 1 is PAL, where the bit equals the phase flag (1 = inverted R−Y line). Code 2 is SECAM, where the bit equals the phase flag (1 = DR line). Code 3 gives 0.
- R8: `valid_o` is 1 during slots 0 to 63 and 0 during slots 64 to 67. The frame lasts 272 cycles, and the block is idle in the cycle after it.
- R9: The increments, standard and phase are captured at the start of a frame. Changing them while the frame is in progress does not alter its bits.
- R10: A request that arrives while a frame is in progress is ignored. The frame running at the time keeps its timing and ends at its normal time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hinc_i | input | 14 | Horizontal loop increment |
| finc_i | input | 23 | Subcarrier loop increment |
| std_i | input | 2 | Colour standard code |
| phase_i | input | 1 | Current line-phase flag |
| frame_req_i | input | 1 | Frame start request |
| sdo_o | output | 1 | Serial frame data, idles high |
| valid_o | output | 1 | High during the valid slots |

## Verification
The bench sweeps single-bit and mixed patterns through both increment fields. It compares every cycle of every frame with a slot map computed in the bench. A swapped bit order or a field shifted by one slot therefore shows up at once. All four standard codes are combined with both phase values. A sequence bit that ignores the standard, or that follows the phase under NTSC, fails in slot 41. Some frames change their inputs partway through. Others re-request a frame partway through. A design without input capture, or one that restarts on a late request, produces bits that do not match the captured values, or ends at the wrong time. The cycles around the valid edge at slot 64 and the return to idle after slot 67 are checked exactly.

// File: rtl/srt_pkg.sv
package srt_pkg;
    parameter int HINC_W = 14;
    parameter int FINC_W = 23;

    typedef enum logic [1:0] {
        STD_NTSC  = 2'd0,
        STD_PAL   = 2'd1,
        STD_SECAM = 2'd2,
        STD_RSVD  = 2'd3
    } std_e;

    typedef struct packed {
        logic [HINC_W-1:0] hinc;
        logic [FINC_W-1:0] finc;
        logic              seq;
    } frame_fields_t;

    // Sequence bit: follows the line phase only on alternating-line standards
    function automatic logic seq_bit(input std_e s, input logic ph);
        case (s)
            STD_PAL, STD_SECAM: return ph;
            default:            return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/srt_timing.sv
module srt_timing #(
    parameter int SLOT_CYCLES = 4,
    parameter int FRAME_SLOTS = 68,
    localparam int SLOT_W = $clog2(FRAME_SLOTS),
    localparam int CYC_W  = $clog2(SLOT_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    output logic              busy,
    output logic              start,
    output logic              done,
    output logic [SLOT_W-1:0] slot
);
    logic [CYC_W-1:0] cyc;
    logic             slot_end;

    assign start    = !busy && req;
    assign slot_end = (cyc == CYC_W'(SLOT_CYCLES-1));
    assign done     = busy && slot_end && (slot == SLOT_W'(FRAME_SLOTS-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            slot <= '0;
            cyc  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            slot <= '0;
            cyc  <= '0;
        end else if (busy) begin
            if (slot_end) begin
                cyc <= '0;
                if (done) begin
                    busy <= 1'b0;
                    slot <= '0;
                end else begin
                    slot <= slot + 1'b1;
                end
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    AST_START_SLOT0: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && slot == '0)); // R3
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !slot_end) |=> $stable(slot)); // R3
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(slot) < FRAME_SLOTS)); // R8
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && req) |=> busy); // R10
endmodule

// File: rtl/srt_shadow.sv
module srt_shadow
    import srt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              done,
    input  logic              busy,
    input  logic [HINC_W-1:0] hinc,
    input  logic [FINC_W-1:0] finc,
    input  logic [1:0]        std,
    input  logic              phase,
    output frame_fields_t     fields
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fields <= '0;
        end else if (start) begin
            fields.hinc <= hinc;
            fields.finc <= finc;
            fields.seq  <= seq_bit(std_e'(std), phase);
        end
    end

    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(fields)); // R9
    AST_NTSC_SEQ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (start && std == STD_NTSC) |=> !fields.seq); // R7
endmodule

// File: rtl/srt_mux.sv
module srt_mux
    import srt_pkg::*;
#(
    parameter int FRAME_SLOTS = 68,
    parameter int VALID_SLOTS = 64,
    parameter int HRES_SLOTS  = 3,
    localparam int SLOT_W  = $clog2(FRAME_SLOTS),
    localparam int HI_W    = $clog2(HINC_W),
    localparam int FI_W    = $clog2(FINC_W),
    localparam int H_FIRST = 1,
    localparam int H_LAST  = H_FIRST + HINC_W - 1,
    localparam int F_FIRST = H_LAST + 1 + HRES_SLOTS,
    localparam int F_LAST  = F_FIRST + FINC_W - 1,
    localparam int SEQ_POS = F_LAST + 1
) (
    input  logic              busy,
    input  logic [SLOT_W-1:0] slot,
    input  frame_fields_t     fields,
    output logic              sdo,
    output logic              valid
);
    int s;

    always_comb begin
        s     = int'(slot);
        sdo   = 1'b1;
        valid = 1'b0;
        if (busy) begin
            valid = (s < VALID_SLOTS);
            sdo   = 1'b0;
            if (s >= H_FIRST && s <= H_LAST)
                sdo = fields.hinc[HI_W'(H_LAST - s)];
            else if (s >= F_FIRST && s <= F_LAST)
                sdo = fields.finc[FI_W'(F_LAST - s)];
            else if (s == SEQ_POS)
                sdo = fields.seq;
        end
    end
endmodule

// File: rtl/ser_pll_frame_tx.sv
module ser_pll_frame_tx
    import srt_pkg::*;
#(
    parameter int SLOT_CYCLES = 4,
    parameter int FRAME_SLOTS = 68,
    parameter int VALID_SLOTS = 64,
    parameter int HRES_SLOTS  = 3,
    localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HINC_W-1:0] hinc_i,
    input  logic [FINC_W-1:0] finc_i,
    input  logic [1:0]        std_i,
    input  logic              phase_i,
    input  logic              frame_req_i,
    output logic              sdo_o,
    output logic              valid_o
);
    logic              busy, start, done;
    logic [SLOT_W-1:0] slot;
    frame_fields_t     fields;

    srt_timing #(.SLOT_CYCLES(SLOT_CYCLES), .FRAME_SLOTS(FRAME_SLOTS)) u_timing (
        .clk(clk), .rst(rst), .req(frame_req_i),
        .busy(busy), .start(start), .done(done), .slot(slot)
    );

    srt_shadow u_shadow (
        .clk(clk), .rst(rst), .start(start), .done(done), .busy(busy),
        .hinc(hinc_i), .finc(finc_i), .std(std_i), .phase(phase_i),
        .fields(fields)
    );

    srt_mux #(.FRAME_SLOTS(FRAME_SLOTS), .VALID_SLOTS(VALID_SLOTS),
              .HRES_SLOTS(HRES_SLOTS)) u_mux (
        .busy(busy), .slot(slot), .fields(fields),
        .sdo(sdo_o), .valid(valid_o)
    );

    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> busy); // R8
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sdo_o && !valid_o)); // R2
    AST_START_EDGE: assert property (@(posedge clk) disable iff (rst)
        start |=> !sdo_o); // R3
endmodule

// File: tb/tb_ser_pll_frame_tx.sv
`timescale 1ns/1ps
module tb_ser_pll_frame_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] hinc = '0;
    logic [22:0] finc = '0;
    logic [1:0]  std = '0;
    logic        phase = 1'b0;
    logic        req = 1'b0;
    logic        sdo, valid;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ser_pll_frame_tx dut (
        .clk(clk), .rst(rst), .hinc_i(hinc), .finc_i(finc), .std_i(std),
        .phase_i(phase), .frame_req_i(req), .sdo_o(sdo), .valid_o(valid)
    );

    function automatic logic exp_bit(int s, logic [13:0] h, logic [22:0] f,
                                     logic [1:0] st, logic ph);
        if (s >= 1 && s <= 14)  return h[14 - s];
        if (s >= 18 && s <= 40) return f[40 - s];
        if (s == 41)            return (st == 2'd1 || st == 2'd2) ? ph : 1'b0;
        return 1'b0;
    endfunction

    function automatic string slot_tag(int s);
        if (s == 0)             return "R3";
        if (s >= 1 && s <= 14)  return "R4";
        if (s >= 18 && s <= 40) return "R6";
        if (s == 41)            return "R7";
        return "R5";
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // mid_change covers R9, mid_req covers R10
    task automatic run_frame(logic [13:0] h, logic [22:0] f, logic [1:0] st,
                             logic ph, bit mid_change, bit mid_req);
        @(negedge clk);
        check("R2", sdo, 1'b1, "idle sdo before frame");
        check("R2", valid, 1'b0, "idle valid before frame");
        hinc = h; finc = f; std = st; phase = ph; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 272; k++) begin
            int s;
            s = k / 4;
            check(slot_tag(s), sdo, exp_bit(s, h, f, st, ph),
                  $sformatf("sdo slot %0d cyc %0d", s, k % 4));
            check("R8", valid, (s < 64), $sformatf("valid slot %0d", s));
            if (mid_change && k == 10) begin
                hinc = ~h; finc = ~f; std = st + 2'd1; phase = ~ph;
            end
            if (mid_req && k == 20)  req = 1'b1;
            if (mid_req && k == 21)  req = 1'b0;
            if (mid_req && k == 271) req = 1'b1;
            @(negedge clk);
        end
        req = 1'b0;
        check("R8", sdo, 1'b1, "sdo idle after 272 cycles");
        check("R10", valid, 1'b0, "valid idle after frame end");
    endtask

    initial begin
        #(5 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1", sdo, 1'b1, "sdo in reset");
        check("R1", valid, 1'b0, "valid in reset");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", sdo, 1'b1, "sdo after reset");
        check("R1", valid, 1'b0, "valid after reset");

        // walking ones through the horizontal field (R4)
        for (int i = 0; i < 14; i++)
            run_frame(14'd1 << i, 23'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        // walking ones through the subcarrier field (R6)
        for (int i = 0; i < 23; i += 2)
            run_frame(14'd0, 23'd1 << i, 2'd0, 1'b1, 1'b0, 1'b0);
        // every standard with both phases (R7)
        for (int st = 0; st < 4; st++)
            for (int ph = 0; ph < 2; ph++)
                run_frame(14'h2A5C, 23'h5A3C96, 2'(st), 1'(ph), 1'b0, 1'b0);
        // all ones, reserved slots stay low (R5)
        run_frame(14'h3FFF, 23'h7FFFFF, 2'd1, 1'b1, 1'b0, 1'b0);
        // inputs change mid-frame (R9)
        run_frame(14'h1234, 23'h13579B, 2'd2, 1'b1, 1'b1, 1'b0);
        run_frame(14'h0F0F, 23'h0F0F0F, 2'd1, 1'b0, 1'b1, 1'b0);
        // re-request during a frame (R10)
        run_frame(14'h3C3C, 23'h2468AC, 2'd2, 1'b0, 1'b0, 1'b1);
        run_frame(14'h0001, 23'h400000, 2'd0, 1'b0, 1'b1, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule